// File: doc/BRIEF.md
# USB Endpoint Interrupt Status Aggregator

This block gathers single-cycle event strobes from a USB function control unit and turns them into sticky status flags. It then combines them into two interrupt requests. Endpoint 0 owns one flag, which merges every control-transfer event. Each data endpoint (1 to `NUM_EPS`) owns an IN flag and an OUT flag. A further shared flag records isochronous overrun and underrun errors. The block detects those errors itself, from the endpoint mode bits and the FIFO occupancy reported beside each host packet or token.

Software reads the flags as two status words through a combinational read port. It clears them by writing ones through a clear port. The block carries no streaming data, so every pin is a plain control or status signal, and nothing is held back by back-pressure.

Top module: `usb_ep_irq_agg`

## Requirements
- R1: After reset all flags are 0, both status words read 0x00, and `func_irq` and `xrun_irq` are low.
- R2: Any one of the five endpoint-0 event strobes (packet received, packet sent, data-end cleared, stall forced, setup-end set) sets only the endpoint-0 flag, which is bit 0 of word 0.
- R3: For data endpoint k (1..4), `ep_tx_ok` sets only the IN flag, at flat status bit 2k-1. Flat bit n sits in word n/8 at bit n%8, so endpoint 4 IN is word 0 bit 7.
- R4: For data endpoint k, `ep_rx_ok` or `ep_stall_set` sets only the OUT flag, at flat status bit 2k. Endpoint 4 OUT is word 1 bit 0.
- R5: When endpoint k is isochronous and `host_out_pkt` arrives while its OUT FIFO holds 2 or more packets, both the OUT flag of k and the overrun/underrun flag (word 1 bit 1) are set. With fewer than 2 packets, nothing is set.
- R6: When endpoint k is isochronous and `host_in_tok` arrives while its IN FIFO is empty, both the IN flag of k and the overrun/underrun flag are set. With a non-empty FIFO, nothing is set.
- R7: For an endpoint that is not isochronous, host packets and tokens set no flag, whatever the FIFO state.
- R8: Flags stay set until cleared. A cycle with `reg_clr_en` high clears the flags whose bit is 1 in `reg_clr_mask` within word `reg_clr_sel`, and leaves every other flag as it was.
- R9: If a flag's set event and its clear arrive in the same cycle, the flag stays at 1.
- R10: `func_irq` is high exactly while any of the nine endpoint flags is 1. It falls only after the last of them has been cleared. The overrun/underrun flag alone does not raise it.
- R11: `xrun_irq` is high exactly while the overrun/underrun flag is 1.
- R12: A flag is set at the first rising clock edge that samples its event, and is not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep0_rx_ok | input | 1 | Endpoint 0 packet received |
| ep0_tx_ok | input | 1 | Endpoint 0 packet sent |
| ep0_data_end_clr | input | 1 | Endpoint 0 data-end bit cleared by control unit |
| ep0_stall_set | input | 1 | Endpoint 0 stall forced |
| ep0_setup_end_set | input | 1 | Endpoint 0 setup-end set |
| ep_tx_ok | input | NUM_EPS | Per data endpoint packet sent (bit 0 = endpoint 1) |
| ep_rx_ok | input | NUM_EPS | Per data endpoint packet received |
| ep_stall_set | input | NUM_EPS | Per data endpoint stall forced |
| ep_iso_mode | input | NUM_EPS | Endpoint configured for isochronous transfer |
| host_out_pkt | input | NUM_EPS | Host OUT data packet arriving at endpoint |
| host_in_tok | input | NUM_EPS | Host IN token arriving at endpoint |
| out_fifo_occ | input | NUM_EPS*OCC_W | Packets held in each OUT FIFO |
| in_fifo_empty | input | NUM_EPS | IN FIFO holds no data |
| reg_sel | input | 1 | Status word selected for reading |
| reg_rdata | output | WORD_W | Selected status word |
| reg_clr_en | input | 1 | Clear strobe |
| reg_clr_sel | input | 1 | Status word targeted by the clear |
| reg_clr_mask | input | WORD_W | Write-1-to-clear mask |
| func_irq | output | 1 | Combined endpoint interrupt request |
| xrun_irq | output | 1 | Overrun/underrun interrupt request |

## Verification
A flag stuck low, or set on the wrong event, appears on `reg_rdata` at the first negative edge after the strobe's capturing edge. This is why each event is pulsed alone and both words are read right after it: a cross-wired event shows up as an extra or missing bit. A clear that reaches the wrong bit, or a lost set-over-clear priority, shows up in the same read one cycle after the clear strobe. A wrong OR in the request logic shows as `func_irq` staying high, or falling early, on the cycle after a partial clear.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  typedef enum logic { WORD_LO = 1'b0, WORD_HI = 1'b1 } stat_word_e;

  typedef struct packed {
    logic rx_ok;
    logic tx_ok;
    logic data_end_clr;
    logic stall_set;
    logic setup_end_set;
  } ep0_evt_t;

  function automatic int in_bit(input int ep_idx);
    return 2 * ep_idx + 1;
  endfunction

  function automatic int out_bit(input int ep_idx);
    return 2 * ep_idx + 2;
  endfunction
endpackage

// File: rtl/usb_sticky_flag.sv
module usb_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && $past(rst_n)) |=> $stable(q_o));
endmodule

// File: rtl/usb_iso_err_det.sv
module usb_iso_err_det #(
  parameter int OCC_W     = 2,
  parameter int OVR_LIMIT = 2
) (
  input  logic             iso_mode_i,
  input  logic             out_pkt_i,
  input  logic             in_tok_i,
  input  logic [OCC_W-1:0] out_occ_i,
  input  logic             in_empty_i,
  output logic             overrun_o,
  output logic             underrun_o
);
  localparam logic [OCC_W-1:0] LIMIT = OCC_W'(OVR_LIMIT);

  always_comb begin
    overrun_o  = iso_mode_i && out_pkt_i && (out_occ_i >= LIMIT);
    underrun_o = iso_mode_i && in_tok_i && in_empty_i;
  end
endmodule

// File: rtl/usb_ep_irq_agg.sv
module usb_ep_irq_agg
  import usb_irq_pkg::*;
#(
  parameter int NUM_EPS   = 4,
  parameter int WORD_W    = 8,
  parameter int OCC_W     = 2,
  parameter int OVR_LIMIT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ep0_rx_ok,
  input  logic                     ep0_tx_ok,
  input  logic                     ep0_data_end_clr,
  input  logic                     ep0_stall_set,
  input  logic                     ep0_setup_end_set,
  input  logic [NUM_EPS-1:0]       ep_tx_ok,
  input  logic [NUM_EPS-1:0]       ep_rx_ok,
  input  logic [NUM_EPS-1:0]       ep_stall_set,
  input  logic [NUM_EPS-1:0]       ep_iso_mode,
  input  logic [NUM_EPS-1:0]       host_out_pkt,
  input  logic [NUM_EPS-1:0]       host_in_tok,
  input  logic [NUM_EPS*OCC_W-1:0] out_fifo_occ,
  input  logic [NUM_EPS-1:0]       in_fifo_empty,
  input  logic                     reg_sel,
  output logic [WORD_W-1:0]        reg_rdata,
  input  logic                     reg_clr_en,
  input  logic                     reg_clr_sel,
  input  logic [WORD_W-1:0]        reg_clr_mask,
  output logic                     func_irq,
  output logic                     xrun_irq
);
  localparam int N_EP_FLAGS = 1 + 2 * NUM_EPS;
  localparam int XRUN_BIT   = N_EP_FLAGS;
  localparam int N_FLAGS    = N_EP_FLAGS + 1;
  localparam int STAT_W     = 2 * WORD_W;

  ep0_evt_t             ep0_evt;
  logic [NUM_EPS-1:0]   overrun, underrun;
  logic [N_FLAGS-1:0]   set_vec, clr_vec, flags;
  logic [STAT_W-1:0]    status;

  assign ep0_evt = '{rx_ok: ep0_rx_ok, tx_ok: ep0_tx_ok,
                     data_end_clr: ep0_data_end_clr,
                     stall_set: ep0_stall_set,
                     setup_end_set: ep0_setup_end_set};

  assign set_vec[0]        = |ep0_evt;
  assign set_vec[XRUN_BIT] = (|overrun) | (|underrun);

  for (genvar k = 0; k < NUM_EPS; k++) begin : g_ep
    usb_iso_err_det #(.OCC_W(OCC_W), .OVR_LIMIT(OVR_LIMIT)) u_det (
      .iso_mode_i (ep_iso_mode[k]),
      .out_pkt_i  (host_out_pkt[k]),
      .in_tok_i   (host_in_tok[k]),
      .out_occ_i  (out_fifo_occ[k*OCC_W +: OCC_W]),
      .in_empty_i (in_fifo_empty[k]),
      .overrun_o  (overrun[k]),
      .underrun_o (underrun[k])
    );
    assign set_vec[in_bit(k)]  = ep_tx_ok[k] | underrun[k];
    assign set_vec[out_bit(k)] = ep_rx_ok[k] | ep_stall_set[k] | overrun[k];
  end

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    localparam stat_word_e WSEL = stat_word_e'(i / WORD_W);
    assign clr_vec[i] = reg_clr_en && (stat_word_e'(reg_clr_sel) == WSEL)
                        && reg_clr_mask[i % WORD_W];
    usb_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flags[i])
    );
  end

  always_comb begin
    status = '0;
    status[N_FLAGS-1:0] = flags;
  end

  assign reg_rdata = (stat_word_e'(reg_sel) == WORD_HI) ? status[STAT_W-1:WORD_W]
                                                        : status[WORD_W-1:0];
  assign func_irq  = |flags[N_EP_FLAGS-1:0];
  assign xrun_irq  = flags[XRUN_BIT];

  a_r10_irq_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(func_irq) |-> $past(reg_clr_en));
  a_r7_xrun_needs_iso: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xrun_irq) |-> $past(|(ep_iso_mode & (host_out_pkt | host_in_tok))));
  a_r11_xrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (xrun_irq && !reg_clr_en) |=> xrun_irq);
endmodule

// File: tb/usb_ep_irq_agg_bench.sv
module usb_ep_irq_agg_bench;
  localparam int CLK_P = 10;
  localparam int NE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic e0_rx = 0, e0_tx = 0, e0_de = 0, e0_st = 0, e0_se = 0;
  logic [NE-1:0] tx_ok = '0, rx_ok = '0, st_set = '0, iso = '0;
  logic [NE-1:0] out_pkt = '0, in_tok = '0, in_empty = '0;
  logic [NE*2-1:0] occ = '0;
  logic rsel = 0, clr_en = 0, clr_sel = 0;
  logic [7:0] clr_mask = '0, rdata;
  logic firq, xirq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  usb_ep_irq_agg u_usb_ep_irq_agg (
    .clk(clk), .rst_n(rst_n),
    .ep0_rx_ok(e0_rx), .ep0_tx_ok(e0_tx), .ep0_data_end_clr(e0_de),
    .ep0_stall_set(e0_st), .ep0_setup_end_set(e0_se),
    .ep_tx_ok(tx_ok), .ep_rx_ok(rx_ok), .ep_stall_set(st_set),
    .ep_iso_mode(iso), .host_out_pkt(out_pkt), .host_in_tok(in_tok),
    .out_fifo_occ(occ), .in_fifo_empty(in_empty),
    .reg_sel(rsel), .reg_rdata(rdata), .reg_clr_en(clr_en),
    .reg_clr_sel(clr_sel), .reg_clr_mask(clr_mask),
    .func_irq(firq), .xrun_irq(xirq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [15:0] exp, input logic fi, input logic xi);
    logic [15:0] w;
    rsel = 0; #1; w[7:0] = rdata;
    rsel = 1; #1; w[15:8] = rdata;
    chk(req, w, exp);
    chk({req, " func_irq"}, 16'(firq), 16'(fi));
    chk({req, " xrun_irq"}, 16'(xirq), 16'(xi));
  endtask

  task automatic clear(input logic sel, input logic [7:0] m);
    clr_en = 1; clr_sel = sel; clr_mask = m;
    @(negedge clk);
    clr_en = 0; clr_mask = '0;
  endtask

  task automatic clear_all();
    clear(1'b0, 8'hFF);
    clear(1'b1, 8'hFF);
  endtask

  task automatic t_reset();
    chk_state("R1", 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_ep0();
    for (int i = 0; i < 5; i++) begin
      {e0_rx, e0_tx, e0_de, e0_st, e0_se} = 5'b10000 >> i;
      if (i == 0) begin
        #1; rsel = 0; #1;
        chk("R12 before edge", 16'(rdata), 16'h0000);
      end
      @(negedge clk);
      {e0_rx, e0_tx, e0_de, e0_st, e0_se} = '0;
      chk_state("R2", 16'h0001, 1'b1, 1'b0);
      clear_all();
      chk_state("R8 ep0 cleared", 16'h0000, 1'b0, 1'b0);
    end
  endtask

  task automatic t_data_eps();
    for (int k = 1; k <= NE; k++) begin
      tx_ok[k-1] = 1; @(negedge clk); tx_ok = '0;
      chk_state("R3", 16'(1) << (2*k-1), 1'b1, 1'b0);
      clear_all();
      rx_ok[k-1] = 1; @(negedge clk); rx_ok = '0;
      chk_state("R4 rx", 16'(1) << (2*k), 1'b1, 1'b0);
      clear_all();
      st_set[k-1] = 1; @(negedge clk); st_set = '0;
      chk_state("R4 stall", 16'(1) << (2*k), 1'b1, 1'b0);
      clear_all();
    end
  endtask

  task automatic t_iso();
    iso = 4'b1111;
    occ = 8'b10_00_00_00; out_pkt = 4'b1000; @(negedge clk); out_pkt = '0;
    chk_state("R5 overrun ep4", 16'h0300, 1'b1, 1'b1);
    clear_all();
    occ = 8'b00_00_01_00; out_pkt = 4'b0010; @(negedge clk); out_pkt = '0;
    chk_state("R5 one packet no overrun", 16'h0000, 1'b0, 1'b0);
    in_empty = 4'b0100; in_tok = 4'b0100; @(negedge clk); in_tok = '0;
    chk_state("R6 underrun ep3", 16'h0220, 1'b1, 1'b1);
    clear(1'b0, 8'h20);
    chk_state("R11 xrun alone", 16'h0200, 1'b0, 1'b1);
    clear_all();
    in_empty = 4'b0000; in_tok = 4'b0001; @(negedge clk); in_tok = '0;
    chk_state("R6 data present no underrun", 16'h0000, 1'b0, 1'b0);
    iso = '0; occ = '0;
  endtask

  task automatic t_noniso();
    iso = 4'b0000; occ = 8'hFF; in_empty = 4'hF;
    out_pkt = 4'hF; in_tok = 4'hF; @(negedge clk);
    out_pkt = '0; in_tok = '0;
    chk_state("R7", 16'h0000, 1'b0, 1'b0);
    occ = '0; in_empty = '0;
  endtask

  task automatic t_partial_clear();
    e0_se = 1; tx_ok = 4'b0010; st_set = 4'b1000; @(negedge clk);
    e0_se = 0; tx_ok = '0; st_set = '0;
    chk_state("R8 three flags", 16'h0109, 1'b1, 1'b0);
    clear(1'b0, 8'h08);
    chk_state("R8 masked clear", 16'h0101, 1'b1, 1'b0);
    clear(1'b0, 8'h01);
    chk_state("R10 one flag left", 16'h0100, 1'b1, 1'b0);
    clear(1'b1, 8'h01);
    chk_state("R10 all cleared", 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_set_wins();
    rx_ok[0] = 1; @(negedge clk); rx_ok = '0;
    rx_ok[0] = 1; clr_en = 1; clr_sel = 0; clr_mask = 8'h04;
    @(negedge clk);
    rx_ok = '0; clr_en = 0; clr_mask = '0;
    chk_state("R9", 16'h0004, 1'b1, 1'b0);
    clear_all();
  endtask

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ep0();
    t_data_eps();
    t_iso();
    t_noniso();
    t_partial_clear();
    t_set_wins();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule